// File: doc/BRIEF.md
# Lane Array with Shared Multipliers

This block is the execute stage of a vector unit in which every one of its lanes carries a simple integer ALU, while only a smaller, separately chosen number of lanes carries a multiplier. One vector instruction is offered per cycle, together with the operands for every element position of a group and an active element count. Add, subtract and bitwise operations finish for the whole group in a single cycle. A multiply is spread over several consecutive cycles. In each of these cycles the available multipliers take the next run of element positions. Each product is returned to the element position it came from.

While the later multiply passes run, the block raises a stall towards the issue stage and ignores any instruction offered. When the last pass completes, the block presents the whole group of results at once, with a per-element valid mask and a one-cycle completion pulse. Element positions at or beyond the active count produce no valid flag and a zero result. When the multiplier count equals the lane count, multiplies behave exactly like ALU operations and no stall ever appears.

Top module: `hl_lane_array`

## Requirements
- R1: After a synchronous reset, `stall`, `instr_done` and every bit of `res_valid` are low.
- R2: An accepted operation with code 0 (add), 1 (subtract), 2 (and), 3 (or) or 4 (xor) raises `instr_done` on the next clock edge, with the result of every active element on `res_data`. Arithmetic wraps modulo 2^DW. Element i occupies bits [i*DW +: DW] of every vector port.
- R3: An accepted multiply (code 5) places the low DW bits of a[i]*b[i] at element position i. `instr_done` rises ceil(LANES/MUL_LANES)-1 cycles later than it would for an ALU operation.
- R4: After a multiply is accepted, `stall` is high for exactly ceil(LANES/MUL_LANES)-1 consecutive cycles, and it falls in the cycle in which `instr_done` is high.
- R5: An instruction offered while `stall` is high is ignored. It changes neither the results nor the number of completion pulses.
- R6: Only elements with index below the active count have their `res_valid` bit set, and their `res_data` field holds the result. Every other field reads zero. A count above LANES acts as LANES. A count of zero still produces one completion pulse, with no valid element.
- R7: ALU operations issued on consecutive cycles are all accepted with no stall. Each one completes on the cycle after its issue.
- R8: Every accepted instruction produces exactly one single-cycle `instr_done` pulse.
- R9: With MUL_LANES equal to LANES, a multiply completes with ALU timing and `stall` never rises.
- R10: When LANES is not a multiple of MUL_LANES, the last multiply pass uses only the multipliers that map to existing element positions. All element positions still receive their correct products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_op | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 multiply |
| issue_vlen | input | $clog2(LANES+1) | Number of active elements, starting at position 0 |
| issue_a | input | LANES*DW | First operand, element i at [i*DW +: DW] |
| issue_b | input | LANES*DW | Second operand, same layout |
| stall | output | 1 | Issue stage must hold; offered instructions are ignored |
| res_data | output | LANES*DW | Result group, element i at [i*DW +: DW] |
| res_valid | output | LANES | Per-element valid, high only with instr_done |
| instr_done | output | 1 | One-cycle pulse when a group of results is presented |

## Verification
The hardest condition to create from the ports is an instruction that arrives while later multiply passes are still running. From the outside it looks like an ordinary issue, and a design that wrongly accepted it would still produce plausible numbers. The stimulus offers an add with different operands in the first stalled cycle. Three instances with different multiplier counts share the same inputs, so the full-multiplier instance does accept that add while the shared instances must drop it. The uneven split with three multipliers for four lanes is covered by its own instance, in which the second pass leaves two multipliers without an element.

// File: rtl/hl_pkg.sv
package hl_pkg;

    typedef enum logic [2:0] {
        HL_ADD = 3'd0,
        HL_SUB = 3'd1,
        HL_AND = 3'd2,
        HL_OR  = 3'd3,
        HL_XOR = 3'd4,
        HL_MUL = 3'd5
    } hl_op_e;

    // Number of passes needed to cover n items with k workers.
    function automatic int hl_passes(input int n, input int k);
        return (n + k - 1) / k;
    endfunction

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int hl_cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hl_alu_lane.sv
module hl_alu_lane #(
    parameter int DW = 16
) (
    input  hl_pkg::hl_op_e  op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    import hl_pkg::*;

    always_comb begin
        unique case (op)
            HL_ADD:  y = a + b;
            HL_SUB:  y = a - b;
            HL_AND:  y = a & b;
            HL_OR:   y = a | b;
            HL_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/hl_mul_group.sv
module hl_mul_group #(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int DW        = 16,
    localparam int PASSES   = hl_pkg::hl_passes(LANES, MUL_LANES),
    localparam int CW       = hl_pkg::hl_cnt_width(PASSES)
) (
    input  logic [CW-1:0]                       pass_idx,
    input  logic [LANES-1:0][DW-1:0]            src_a,
    input  logic [LANES-1:0][DW-1:0]            src_b,
    output logic [MUL_LANES-1:0][LANES-1:0]     route,
    output logic [MUL_LANES-1:0][DW-1:0]        prod
);
    logic [MUL_LANES-1:0][DW-1:0] mul_a;
    logic [MUL_LANES-1:0][DW-1:0] mul_b;

    // Operand steering: multiplier j serves element pass_idx*MUL_LANES + j.
    always_comb begin
        for (int j = 0; j < MUL_LANES; j++) begin
            mul_a[j] = '0;
            mul_b[j] = '0;
            for (int i = 0; i < LANES; i++) begin
                route[j][i] = (i == int'(pass_idx) * MUL_LANES + j);
                if (route[j][i]) begin
                    mul_a[j] = mul_a[j] | src_a[i];
                    mul_b[j] = mul_b[j] | src_b[i];
                end
            end
        end
    end

    for (genvar j = 0; j < MUL_LANES; j++) begin : g_mul
        hl_mul_unit #(.DW(DW)) u_mul (
            .a (mul_a[j]),
            .b (mul_b[j]),
            .p (prod[j])
        );
    end
endmodule

// File: rtl/hl_mul_unit.sv
module hl_mul_unit #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] p
);
    // Low half of the product; wraps modulo 2^DW.
    assign p = a * b;
endmodule

// File: rtl/hl_result_merge.sv
module hl_result_merge #(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int DW        = 16
) (
    input  logic [LANES-1:0][DW-1:0]        base,
    input  logic [MUL_LANES-1:0][LANES-1:0] route,
    input  logic [MUL_LANES-1:0][DW-1:0]    prod,
    output logic [LANES-1:0][DW-1:0]        merged
);
    // Result steering: each product returns to the element it was taken from.
    always_comb begin
        merged = base;
        for (int j = 0; j < MUL_LANES; j++) begin
            for (int i = 0; i < LANES; i++) begin
                if (route[j][i]) merged[i] = prod[j];
            end
        end
    end
endmodule

// File: rtl/hl_lane_array.sv
module hl_lane_array #(
    parameter int LANES     = 4,
    parameter int MUL_LANES = 2,
    parameter int DW        = 16,
    localparam int VLW      = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_valid,
    input  logic [2:0]            issue_op,
    input  logic [VLW-1:0]        issue_vlen,
    input  logic [LANES*DW-1:0]   issue_a,
    input  logic [LANES*DW-1:0]   issue_b,
    output logic                  stall,
    output logic [LANES*DW-1:0]   res_data,
    output logic [LANES-1:0]      res_valid,
    output logic                  instr_done
);
    import hl_pkg::*;

    localparam int PASSES = hl_passes(LANES, MUL_LANES);
    localparam int CW     = hl_cnt_width(PASSES);
    localparam logic [CW-1:0] LAST_PASS = CW'(PASSES - 1);

    hl_op_e                       op_in;
    logic [LANES-1:0][DW-1:0]     in_a, in_b;
    logic [VLW-1:0]               vl_in, vl_cur;
    logic [LANES-1:0]             mask_in, mask_cur;

    logic                         busy_q;
    logic [CW-1:0]                pass_q;
    logic [LANES-1:0][DW-1:0]     hold_a_q, hold_b_q, acc_q;
    logic [VLW-1:0]               vlen_q;
    logic [LANES-1:0][DW-1:0]     res_q;
    logic [LANES-1:0]             res_valid_q;
    logic                         done_q;

    logic                         accept, alu_accept, mul_accept, mul_active, last_pass;
    logic [CW-1:0]                pass_idx;
    logic [LANES-1:0][DW-1:0]     src_a, src_b, acc_base, acc_next;
    logic [LANES-1:0][DW-1:0]     alu_y, alu_masked, mul_masked;
    logic [MUL_LANES-1:0][LANES-1:0] route;
    logic [MUL_LANES-1:0][DW-1:0] prod;

    assign op_in = hl_op_e'(issue_op);
    assign in_a  = issue_a;
    assign in_b  = issue_b;
    assign vl_in = (issue_vlen > VLW'(LANES)) ? VLW'(LANES) : issue_vlen;

    // Issue control
    assign accept     = issue_valid && !busy_q;
    assign mul_accept = accept && (op_in == HL_MUL);
    assign alu_accept = accept && (op_in != HL_MUL);
    assign mul_active = mul_accept || busy_q;
    assign pass_idx   = busy_q ? pass_q : '0;
    assign last_pass  = (pass_idx == LAST_PASS);
    assign vl_cur     = busy_q ? vlen_q : vl_in;

    // The first pass runs straight from the issue operands; later passes use the held copy.
    assign src_a    = busy_q ? hold_a_q : in_a;
    assign src_b    = busy_q ? hold_b_q : in_b;
    assign acc_base = busy_q ? acc_q    : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        hl_alu_lane #(.DW(DW)) u_alu (
            .op (op_in),
            .a  (in_a[i]),
            .b  (in_b[i]),
            .y  (alu_y[i])
        );
        assign mask_in[i]    = (VLW'(i) < vl_in);
        assign mask_cur[i]   = (VLW'(i) < vl_cur);
        assign alu_masked[i] = mask_in[i]  ? alu_y[i]    : '0;
        assign mul_masked[i] = mask_cur[i] ? acc_next[i] : '0;
    end

    hl_mul_group #(.LANES(LANES), .MUL_LANES(MUL_LANES), .DW(DW)) u_mgrp (
        .pass_idx (pass_idx),
        .src_a    (src_a),
        .src_b    (src_b),
        .route    (route),
        .prod     (prod)
    );

    hl_result_merge #(.LANES(LANES), .MUL_LANES(MUL_LANES), .DW(DW)) u_merge (
        .base   (acc_base),
        .route  (route),
        .prod   (prod),
        .merged (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            pass_q      <= '0;
            hold_a_q    <= '0;
            hold_b_q    <= '0;
            acc_q       <= '0;
            vlen_q      <= '0;
            res_q       <= '0;
            res_valid_q <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            res_valid_q <= '0;
            if (alu_accept) begin
                res_q       <= alu_masked;
                res_valid_q <= mask_in;
                done_q      <= 1'b1;
            end else if (mul_active) begin
                if (mul_accept) begin
                    hold_a_q <= in_a;
                    hold_b_q <= in_b;
                    vlen_q   <= vl_in;
                end
                if (last_pass) begin
                    res_q       <= mul_masked;
                    res_valid_q <= mask_cur;
                    done_q      <= 1'b1;
                    busy_q      <= 1'b0;
                    pass_q      <= '0;
                end else begin
                    acc_q  <= acc_next;
                    busy_q <= 1'b1;
                    pass_q <= pass_idx + CW'(1);
                end
            end
        end
    end

    assign stall      = busy_q;
    assign res_data   = res_q;
    assign res_valid  = res_valid_q;
    assign instr_done = done_q;

    // Assertions
    int unsigned stall_run;
    always_ff @(posedge clk) begin
        if (rst)        stall_run <= 0;
        else if (stall) stall_run <= stall_run + 1;
        else            stall_run <= 0;
    end

    assert_valid_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid != '0) |-> instr_done);

    assert_alu_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !stall && issue_op != 3'd5) |=> instr_done);

    assert_stall_ends_done_R4: assert property (@(posedge clk) disable iff (rst)
        (stall) |=> (stall || instr_done));

    assert_done_not_stalled_R4: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> !stall);

    assert_stall_bound_R4: assert property (@(posedge clk) disable iff (rst)
        stall_run <= PASSES - 1);

    assert_stall_after_mul_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> !instr_done);

    if (PASSES > 1) begin : g_shared_chk
        assert_mul_stalls_R3: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && !stall && issue_op == 3'd5) |=> (stall && !instr_done));
    end else begin : g_full_chk
        assert_never_stall_R9: assert property (@(posedge clk) disable iff (rst)
            !stall);
        assert_mul_fast_R9: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && issue_op == 3'd5) |=> instr_done);
    end
endmodule

// File: tb/tb_hl_lane_array.sv
module tb_hl_lane_array;
    localparam int  LANES  = 4;
    localparam int  DW     = 16;
    localparam int  NDUT   = 3;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [2:0]          op;
        logic [2:0]          vl;
        logic [LANES*DW-1:0] a;
        logic [LANES*DW-1:0] b;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd4, 64'h0001_0002_0003_FFFF, 64'h0001_0001_0001_0001},
        '{3'd1, 3'd4, 64'h0000_0005_0010_0100, 64'h0001_0003_0010_0001},
        '{3'd2, 3'd4, 64'hF0F0_FFFF_1234_00FF, 64'h0FF0_AAAA_FFFF_0F0F},
        '{3'd3, 3'd2, 64'h1000_0200_0030_0004, 64'h0001_0010_0100_1000},
        '{3'd4, 3'd1, 64'hAAAA_5555_FFFF_1234, 64'h5555_5555_00FF_4321},
        '{3'd5, 3'd4, 64'h0002_0003_0004_0005, 64'h0007_0100_FFFF_0003},
        '{3'd5, 3'd3, 64'h0010_0011_0012_0013, 64'h0002_0003_0004_0005},
        '{3'd5, 3'd0, 64'h0009_0009_0009_0009, 64'h0009_0009_0009_0009},
        '{3'd5, 3'd7, 64'h8000_0101_00FF_7FFF, 64'h0002_0101_0101_0002},
        '{3'd0, 3'd6, 64'h0010_0020_0030_0040, 64'h0001_0002_0003_0004}
    };

    // Passes needed per instance: (4,2) -> 2, (4,3) -> 2, (4,4) -> 1.
    localparam int PASSES [NDUT] = '{2, 2, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic                 issue_valid = 1'b0;
    logic [2:0]           issue_op    = '0;
    logic [2:0]           issue_vlen  = '0;
    logic [LANES*DW-1:0]  issue_a     = '0;
    logic [LANES*DW-1:0]  issue_b     = '0;

    logic [NDUT-1:0]                stall_v;
    logic [NDUT-1:0]                done_v;
    logic [NDUT-1:0][LANES-1:0]     valid_v;
    logic [NDUT-1:0][LANES*DW-1:0]  res_v;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hl_lane_array #(.LANES(LANES), .MUL_LANES(2), .DW(DW)) dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vlen(issue_vlen), .issue_a(issue_a), .issue_b(issue_b),
        .stall(stall_v[0]), .res_data(res_v[0]), .res_valid(valid_v[0]), .instr_done(done_v[0]));

    hl_lane_array #(.LANES(LANES), .MUL_LANES(3), .DW(DW)) dut_odd (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vlen(issue_vlen), .issue_a(issue_a), .issue_b(issue_b),
        .stall(stall_v[1]), .res_data(res_v[1]), .res_valid(valid_v[1]), .instr_done(done_v[1]));

    hl_lane_array #(.LANES(LANES), .MUL_LANES(4), .DW(DW)) dut_full (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vlen(issue_vlen), .issue_a(issue_a), .issue_b(issue_b),
        .stall(stall_v[2]), .res_data(res_v[2]), .res_valid(valid_v[2]), .instr_done(done_v[2]));

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int eff_vl(input logic [2:0] vl);
        return (int'(vl) > LANES) ? LANES : int'(vl);
    endfunction

    function automatic logic [LANES*DW-1:0] model(input logic [2:0] op, input logic [2:0] vl,
                                                 input logic [LANES*DW-1:0] a,
                                                 input logic [LANES*DW-1:0] b);
        logic [LANES*DW-1:0] r = '0;
        for (int i = 0; i < eff_vl(vl); i++) begin
            logic [DW-1:0] x = a[i*DW +: DW];
            logic [DW-1:0] y = b[i*DW +: DW];
            logic [2*DW-1:0] p = x * y;
            case (op)
                3'd0: r[i*DW +: DW] = x + y;
                3'd1: r[i*DW +: DW] = x - y;
                3'd2: r[i*DW +: DW] = x & y;
                3'd3: r[i*DW +: DW] = x | y;
                3'd4: r[i*DW +: DW] = x ^ y;
                3'd5: r[i*DW +: DW] = p[DW-1:0];
                default: r[i*DW +: DW] = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] model_mask(input logic [2:0] vl);
        logic [LANES-1:0] m = '0;
        for (int i = 0; i < eff_vl(vl); i++) m[i] = 1'b1;
        return m;
    endfunction

    // Offer one instruction, then watch every instance for five cycles.
    task automatic run_one(input vec_t v);
        int  done_at [NDUT];
        int  ndone   [NDUT];
        int  nstall  [NDUT];
        logic [LANES*DW-1:0] got_r [NDUT];
        logic [LANES-1:0]    got_m [NDUT];
        logic [LANES*DW-1:0] exp_r = model(v.op, v.vl, v.a, v.b);
        logic [LANES-1:0]    exp_m = model_mask(v.vl);
        for (int d = 0; d < NDUT; d++) begin
            done_at[d] = -1; ndone[d] = 0; nstall[d] = 0; got_r[d] = '0; got_m[d] = '0;
        end
        @(negedge clk);
        issue_valid = 1'b1; issue_op = v.op; issue_vlen = v.vl; issue_a = v.a; issue_b = v.b;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int c = 0; c < 5; c++) begin
            for (int d = 0; d < NDUT; d++) begin
                if (stall_v[d]) nstall[d]++;
                if (done_v[d]) begin
                    ndone[d]++;
                    if (done_at[d] < 0) begin
                        done_at[d] = c; got_r[d] = res_v[d]; got_m[d] = valid_v[d];
                    end
                end
            end
            @(negedge clk);
        end
        for (int d = 0; d < NDUT; d++) begin
            int exp_at = (v.op == 3'd5) ? PASSES[d] - 1 : 0;
            // R2 R3 R9 R10: result data at each element position
            check(got_r[d] == exp_r, (v.op == 3'd5) ? (d == 1 ? "R10" : "R3") : "R2", got_r[d], exp_r);
            // R6: per-element valid mask follows the active count
            check(got_m[d] == exp_m, "R6", 64'(got_m[d]), 64'(exp_m));
            // R3 R9: completion cycle
            check(done_at[d] == exp_at, (d == 2) ? "R9" : "R3", 64'(done_at[d]), 64'(exp_at));
            // R4: stall length
            check(nstall[d] == exp_at, "R4", 64'(nstall[d]), 64'(exp_at));
            // R8: one pulse
            check(ndone[d] == 1, "R8", 64'(ndone[d]), 64'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held low during and right after reset
        check(stall_v == '0 && done_v == '0 && valid_v == '0, "R1",
              64'({stall_v, done_v}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(stall_v == '0 && done_v == '0 && valid_v == '0, "R1",
              64'({stall_v, done_v}), 64'd0);

        for (int k = 0; k < NVEC; k++) run_one(VECS[k]);

        // R5: an add offered in the first stalled cycle is dropped by the shared instances
        begin
            logic [LANES*DW-1:0] ma = 64'h0003_0004_0005_0006;
            logic [LANES*DW-1:0] mb = 64'h0010_0010_0010_0010;
            logic [LANES*DW-1:0] xa = 64'h1111_2222_3333_4444;
            logic [LANES*DW-1:0] exp_mul = model(3'd5, 3'd4, ma, mb);
            logic [LANES*DW-1:0] exp_add = model(3'd0, 3'd4, xa, mb);
            int  ndone [NDUT];
            logic [LANES*DW-1:0] last_r [NDUT];
            for (int d = 0; d < NDUT; d++) begin ndone[d] = 0; last_r[d] = '0; end
            @(negedge clk);
            issue_valid = 1'b1; issue_op = 3'd5; issue_vlen = 3'd4; issue_a = ma; issue_b = mb;
            @(negedge clk);
            issue_op = 3'd0; issue_a = xa;
            for (int c = 0; c < 5; c++) begin
                for (int d = 0; d < NDUT; d++) begin
                    if (done_v[d]) begin ndone[d]++; last_r[d] = res_v[d]; end
                end
                @(negedge clk);
                issue_valid = 1'b0;
            end
            check(ndone[0] == 1, "R5", 64'(ndone[0]), 64'd1);
            check(last_r[0] == exp_mul, "R5", last_r[0], exp_mul);
            check(ndone[1] == 1, "R5", 64'(ndone[1]), 64'd1);
            check(last_r[1] == exp_mul, "R5", last_r[1], exp_mul);
            // R9: the full-multiplier instance is never stalled and takes the add
            check(ndone[2] == 2, "R9", 64'(ndone[2]), 64'd2);
            check(last_r[2] == exp_add, "R9", last_r[2], exp_add);
        end

        // R7: back-to-back ALU operations
        begin
            logic [LANES*DW-1:0] a1 = 64'h0001_0002_0003_0004;
            logic [LANES*DW-1:0] b1 = 64'h0010_0020_0030_0040;
            logic [LANES*DW-1:0] e1 = model(3'd0, 3'd4, a1, b1);
            logic [LANES*DW-1:0] e2 = model(3'd1, 3'd4, b1, a1);
            @(negedge clk);
            issue_valid = 1'b1; issue_op = 3'd0; issue_vlen = 3'd4; issue_a = a1; issue_b = b1;
            @(negedge clk);
            for (int d = 0; d < NDUT; d++) begin
                check(done_v[d] && !stall_v[d] && res_v[d] == e1, "R7", res_v[d], e1);
            end
            issue_op = 3'd1; issue_a = b1; issue_b = a1;
            @(negedge clk);
            issue_valid = 1'b0;
            for (int d = 0; d < NDUT; d++) begin
                check(done_v[d] && !stall_v[d] && res_v[d] == e2, "R7", res_v[d], e2);
            end
            @(negedge clk);
            check(done_v == '0, "R8", 64'(done_v), 64'd0);
        end

        summary();
    end
endmodule